// File: doc/BRIEF.md
# Breaker Pole-Open Detector

This block decides, for each of the three phases and for the breaker as a whole, whether the poles are open. A phase reads as open when two things are both true: its breaker auxiliary status shows the pole not closed, and its low-set phase current flag is clear. When the installation has no breaker status wired, the `status_ok` input is held low. In that case the status bits are ignored and the decision rests on the current flags alone.

Three outputs are produced. Per-phase open flags appear one clock after the inputs are sampled. A single-pole-open flag is raised when some, but not all, phases are open and single-pole operation is enabled. A three-pole-open flag picks up at once, with no pickup delay. It drops out only after a programmable number of cycle strobes has passed, so that pole scatter while the breaker closes does not make it chatter. The strobe marks one power-system cycle. The current detectors themselves lie outside the block.

Top module: `pole_open_detect`

## Requirements
- R1: With `status_ok` = 1, bit i of `phase_open` is 1 one clock after the block samples `brk_closed[i]` = 0 together with `cur_det[i]` = 0. It is 0 one clock after either of those bits is 1.
- R2: With `status_ok` = 0, bit i of `phase_open` is 1 one clock after `cur_det[i]` = 0, whatever value `brk_closed` has.
- R3: `three_pole_open` rises one clock after all three phases read open, with no pickup delay.
- R4: Once the all-open condition goes away, `three_pole_open` stays high for N further cycle strobes, where N is the `dropout_set` value loaded while the condition was present. It clears on the first clock at which the condition is absent and the count has reached zero. Clocks with no strobe do not count. With N = 0 it clears one clock after the condition goes away.
- R5: If all phases read open again during the dropout countdown, the countdown is cancelled, reloaded from `dropout_set`, and the output stays high.
- R6: With `sp_enable` = 1, `single_pole_open` is 1 one clock after exactly one or exactly two phases read open. It is 0 when zero phases or all three phases read open.
- R7: With `sp_enable` = 0, `single_pole_open` is 0.
- R8: A `dropout_set` value above 8000 acts as 8000.
- R9: While `rst_n` is low at a clock edge, all outputs go to 0 and the dropout count clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe per power-system cycle |
| brk_closed | input | 3 | Per-phase breaker auxiliary status, 1 = pole closed |
| status_ok | input | 1 | 1 = breaker status is wired and valid |
| cur_det | input | 3 | Per-phase low-set current detector, 1 = current present |
| sp_enable | input | 1 | Enables single-pole-open reporting |
| dropout_set | input | 13 | Dropout delay of three-pole-open, in cycles |
| phase_open | output | 3 | Per-phase open flags |
| single_pole_open | output | 1 | One or two phases open, when enabled |
| three_pole_open | output | 1 | All poles open, with delayed dropout |

## Verification
The hardest states to reach from the ports lie inside the dropout window. One is the all-open condition coming back partway through the countdown. The other is a setting above the cap, which needs thousands of strobes before the output falls. The stimulus drives the breaker open, lets the condition lapse, and then spaces the strobes unevenly so that clocks without a strobe must not count. Part of the way through, it re-opens all phases to check that the countdown reloads. A long run with the setting at its maximum code and a strobe on every clock then measures the exact clock at which the clamped count expires.

// File: rtl/pod_pkg.sv
// Package: shared constants and helpers for the pole-open detector.
// Assumes three phases; the dropout cap is fixed by the protection scheme.
package pod_pkg;
    localparam int POD_PHASES   = 3;
    localparam int POD_MAX_DROP = 8000;
    localparam int POD_DROP_W   = 13;
endpackage

// File: rtl/pod_phase_eval.sv
// Per-phase open evaluation.
// A phase is open when its current flag is clear and either its breaker
// status shows the pole not closed or no status is wired. Provides the raw
// (same-cycle) result for downstream logic and a registered copy for output.
module pod_phase_eval #(
    parameter int N_PH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PH-1:0] brk_closed,
    input  logic            status_ok,
    input  logic [N_PH-1:0] cur_det,
    output logic [N_PH-1:0] open_now,
    output logic [N_PH-1:0] open_q
);
    for (genvar p = 0; p < N_PH; p++) begin : g_phase
        // combine status and current for one phase
        always_comb begin
            open_now[p] = !cur_det[p] && (!status_ok || !brk_closed[p]);
        end

        // register the per-phase decision
        always_ff @(posedge clk) begin
            if (!rst_n) open_q[p] <= 1'b0;
            else        open_q[p] <= open_now[p];
        end
    end
endmodule

// File: rtl/pod_sp_detect.sv
// Single-pole-open detection.
// Counts the open phases and flags a partial opening (some but not all)
// when single-pole mode is enabled. Output is registered.
module pod_sp_detect #(
    parameter int N_PH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sp_enable,
    input  logic [N_PH-1:0] open_now,
    output logic            sp_open_q
);
    logic [31:0] n_open;
    logic        partial;

    // count the phases that read open
    always_comb begin
        n_open = 32'd0;
        for (int i = 0; i < N_PH; i++) begin
            n_open = n_open + {31'd0, open_now[i]};
        end
        partial = (n_open != 32'd0) && (n_open != 32'(N_PH));
    end

    // register the gated single-pole flag
    always_ff @(posedge clk) begin
        if (!rst_n) sp_open_q <= 1'b0;
        else        sp_open_q <= sp_enable && partial;
    end
endmodule

// File: rtl/pod_dropout_timer.sv
// Three-pole-open output with instant pickup and strobe-counted dropout.
// While all phases are open the counter is reloaded with the clamped setting.
// Once they are not, it counts down on each cycle strobe, and the output
// clears on the first clock that sees the count at zero.
module pod_dropout_timer #(
    parameter int MAX_DROP = 8000,
    parameter int DROP_W   = 13,
    localparam int CNT_W   = $clog2(MAX_DROP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              all_open,
    input  logic [DROP_W-1:0] dropout_set,
    output logic              tpo_q,
    output logic [CNT_W-1:0]  cnt_q
);
    logic [CNT_W-1:0] load_val;

    // clamp the setting to the supported maximum
    always_comb begin
        if (32'(dropout_set) > 32'(MAX_DROP)) load_val = CNT_W'(MAX_DROP);
        else                                  load_val = CNT_W'(dropout_set);
    end

    // pickup, reload and countdown of the three-pole-open flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpo_q <= 1'b0;
            cnt_q <= '0;
        end else if (all_open) begin
            tpo_q <= 1'b1;
            cnt_q <= load_val;
        end else if (tpo_q) begin
            if (cnt_q == '0)  tpo_q <= 1'b0;
            else if (cyc_stb) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pole_open_detect.sv
// Top: breaker pole-open detector.
// Joins the per-phase evaluation, the single-pole detector and the
// three-pole dropout timer. Inputs are taken as already synchronous to clk.
module pole_open_detect #(
    parameter int N_PH     = pod_pkg::POD_PHASES,
    parameter int MAX_DROP = pod_pkg::POD_MAX_DROP,
    parameter int DROP_W   = pod_pkg::POD_DROP_W,
    localparam int CNT_W   = $clog2(MAX_DROP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic [N_PH-1:0]   brk_closed,
    input  logic              status_ok,
    input  logic [N_PH-1:0]   cur_det,
    input  logic              sp_enable,
    input  logic [DROP_W-1:0] dropout_set,
    output logic [N_PH-1:0]   phase_open,
    output logic              single_pole_open,
    output logic              three_pole_open
);
    logic [N_PH-1:0]  open_now;
    logic [CNT_W-1:0] dly_cnt;

    pod_phase_eval #(.N_PH(N_PH)) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_closed (brk_closed),
        .status_ok  (status_ok),
        .cur_det    (cur_det),
        .open_now   (open_now),
        .open_q     (phase_open)
    );

    pod_sp_detect #(.N_PH(N_PH)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sp_enable (sp_enable),
        .open_now  (open_now),
        .sp_open_q (single_pole_open)
    );

    pod_dropout_timer #(.MAX_DROP(MAX_DROP), .DROP_W(DROP_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .all_open    (&open_now),
        .dropout_set (dropout_set),
        .tpo_q       (three_pole_open),
        .cnt_q       (dly_cnt)
    );
endmodule

// File: rtl/pod_checker.sv
// Checker: temporal properties of the pole-open detector, bound to the top.
module pod_checker #(
    parameter int N_PH     = 3,
    parameter int MAX_DROP = 8000,
    parameter int CNT_W    = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_PH-1:0]  cur_det,
    input logic             status_ok,
    input logic             sp_enable,
    input logic [N_PH-1:0]  phase_open,
    input logic             single_pole_open,
    input logic             three_pole_open,
    input logic [CNT_W-1:0] cnt
);
    AST_CUR_BLOCKS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_det != '0) |=> ((phase_open & $past(cur_det)) == '0)); // R1
    AST_NOSTATUS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_ok && cur_det == '0) |=> (&phase_open)); // R2
    AST_PICKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (&phase_open) |-> three_pole_open); // R3
    AST_RISE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(three_pole_open) |-> (&phase_open)); // R3
    AST_HOLD_WHILE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (three_pole_open && cnt != '0) |=> three_pole_open); // R4
    AST_SP_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        single_pole_open |-> (phase_open != '0 && !(&phase_open))); // R6
    AST_SP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        single_pole_open |-> $past(sp_enable)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= MAX_DROP); // R8
endmodule

bind pole_open_detect pod_checker #(
    .N_PH(N_PH), .MAX_DROP(MAX_DROP), .CNT_W(CNT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cur_det          (cur_det),
    .status_ok        (status_ok),
    .sp_enable        (sp_enable),
    .phase_open       (phase_open),
    .single_pole_open (single_pole_open),
    .three_pole_open  (three_pole_open),
    .cnt              (dly_cnt)
);

// File: tb/sim_pole_open_detect.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a step and queues the expected
// outputs from its own requirement model; the monitor compares after the edge.
module sim_pole_open_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic [2:0]  brk_closed = 3'b111;
    logic        status_ok = 1'b1;
    logic [2:0]  cur_det = 3'b111;
    logic        sp_enable = 1'b0;
    logic [12:0] dropout_set = 13'd0;
    logic [2:0]  phase_open;
    logic        single_pole_open;
    logic        three_pole_open;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];
    logic       m_tpo = 1'b0;
    int         m_cnt = 0;

    always #4 clk = ~clk;

    pole_open_detect u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .brk_closed(brk_closed),
        .status_ok(status_ok), .cur_det(cur_det), .sp_enable(sp_enable),
        .dropout_set(dropout_set), .phase_open(phase_open),
        .single_pole_open(single_pole_open), .three_pole_open(three_pole_open)
    );

    // driver: apply inputs at negedge and queue the outputs expected after the next edge
    task automatic step(input logic [2:0] brk, input logic st, input logic [2:0] cur,
                        input logic spe, input int drop, input logic stb, input string tag);
        logic [2:0] raw;
        int n;
        int eff;
        logic sp;
        @(negedge clk);
        brk_closed = brk; status_ok = st; cur_det = cur;
        sp_enable = spe; dropout_set = 13'(drop); cyc_stb = stb;
        raw = ~cur & ({3{~st}} | ~brk);
        n = int'(raw[0]) + int'(raw[1]) + int'(raw[2]);
        sp = spe && (n == 1 || n == 2);
        eff = (drop > 8000) ? 8000 : drop;
        if (n == 3) begin
            m_tpo = 1'b1; m_cnt = eff;
        end else if (m_tpo) begin
            if (m_cnt == 0) m_tpo = 1'b0;
            else if (stb)   m_cnt = m_cnt - 1;
        end
        exp_q.push_back({raw, sp, m_tpo});
        tag_q.push_back(tag);
    endtask

    // monitor: pop and compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                logic [4:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {phase_open, single_pole_open, three_pole_open};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: {phase_open,sp,tpo} actual=%b expected=%b", t, a, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if ({phase_open, single_pole_open, three_pole_open} !== 5'b0) begin
            errors++;
            $display("FAIL R9: outputs actual=%b expected=00000",
                     {phase_open, single_pole_open, three_pole_open});
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: status wired, per-phase open needs both status and current clear
        step(3'b010, 1, 3'b000, 0, 3, 0, "R1");
        step(3'b000, 1, 3'b001, 0, 3, 0, "R1");
        step(3'b110, 1, 3'b100, 0, 3, 1, "R1");
        // R2: no status, breaker bits ignored
        step(3'b111, 0, 3'b010, 0, 3, 0, "R2");
        step(3'b101, 0, 3'b111, 0, 3, 0, "R2");
        // R6 / R7: single-pole gating
        step(3'b110, 1, 3'b110, 1, 3, 0, "R6");
        step(3'b100, 1, 3'b100, 1, 3, 0, "R6");
        step(3'b111, 1, 3'b111, 1, 3, 0, "R6");
        step(3'b100, 1, 3'b100, 0, 3, 0, "R7");
        // R3: instant pickup; R4: dropout counted on strobes only
        step(3'b000, 1, 3'b000, 1, 3, 0, "R3");
        step(3'b000, 1, 3'b001, 1, 3, 1, "R4");
        step(3'b000, 1, 3'b001, 1, 3, 0, "R4");
        step(3'b000, 1, 3'b001, 1, 3, 0, "R4");
        step(3'b000, 1, 3'b001, 1, 3, 1, "R4");
        // R5: condition returns mid-countdown and reloads
        step(3'b000, 1, 3'b000, 1, 3, 0, "R5");
        for (int i = 0; i < 6; i++) step(3'b111, 1, 3'b111, 1, 3, 1, "R5");
        // R4: zero dropout clears one clock after the condition goes away
        step(3'b000, 0, 3'b000, 0, 0, 0, "R4");
        step(3'b000, 0, 3'b100, 0, 0, 0, "R4");
        step(3'b000, 0, 3'b100, 0, 0, 0, "R4");
        // R8: setting above the cap acts as 8000 strobes
        step(3'b000, 1, 3'b000, 0, 8191, 1, "R8");
        for (int i = 0; i < 8004; i++) step(3'b111, 1, 3'b111, 0, 8191, 1, "R8");
        // R9: reset mid-operation clears everything
        step(3'b000, 1, 3'b000, 0, 5, 0, "R9");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        checks++;
        if ({phase_open, single_pole_open, three_pole_open} !== 5'b0) begin
            errors++;
            $display("FAIL R9: outputs actual=%b expected=00000",
                     {phase_open, single_pole_open, three_pole_open});
        end
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule